// File: doc/BRIEF.md
# Cascadable Serial-Load Latched Output Controller

This block is the logic core of a display driver channel. Data arrives one bit at a time on a serial input and is moved into a chain of storage stages by the falling edges of a slow shift clock. A bank of level-sensitive latches copies the chain onto a parallel output word whenever the latch enable is high. When the latch enable is low, the latches keep their last value, so new data can be shifted in while the display keeps showing the old frame. A blank input forces the whole parallel word low without disturbing any stored data.

The last stage of the chain is brought out as a serial output. Connecting it to the serial input of another copy of the block extends the chain in steps of one device width. All four control inputs are asynchronous to the block. A system clock at least four times faster than the shift clock samples them through two-flop synchronizers, and every register updates on that system clock. The reset is synchronous and active high.

Top module: `sld_driver`

## Requirements
- R1: On each high-to-low transition of the shift clock, stage 1 takes the serial input bit and every other stage takes the previous contents of the stage before it.
- R2: While the shift clock stays steady high or steady low, the chain contents do not change, whatever the serial input does.
- R3: While latch enable is high, every latch follows its chain stage.
- R4: While latch enable is low, the latches keep their values while the chain shifts.
- R5: While blank is high, all bits of the parallel output are low.
- R6: While blank is low, each parallel output bit shows its latch bit.
- R7: The serial output carries the last stage, changes only when a shift occurs, and lets two devices in series move a 64-bit word.
- R8: Synchronous reset clears the chain and the latches, so the parallel and serial outputs read zero once reset is released.
- R9: Parallel output bit 0 is stage 1, next to the serial input, and bit N-1 is the stage that drives the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the shift clock |
| rst | input | 1 | Synchronous reset, active high |
| sin | input | 1 | Serial data input |
| sclk | input | 1 | Shift clock; a falling edge shifts |
| latch_en | input | 1 | Latch enable, transparent while high |
| blank | input | 1 | Forces the parallel output low while high |
| pout | output | N (32) | Parallel output word |
| sout | output | 1 | Serial output from the last stage |

## Verification
The bench feeds a single 1 into a cleared chain with the latches open. This exposes a reversed bit order, which would light bit N-1 instead of bit 0, and a shift on the wrong edge, which would move the bit early or twice. The bench holds the shift clock steady in both phases while it toggles the serial input, which catches a design that samples data at a level rather than at an edge. It shifts whole words with the latch closed and with blank set, then releases blank. A latch that leaks, or a blank that corrupts the stored data, would show up as a changed word. A 64-bit transfer through two devices in series catches a serial output that moves a cycle early and so drops or duplicates a bit at the device boundary.

// File: rtl/sld_pkg.sv
package sld_pkg;

    // Asynchronous control inputs, sampled together through one synchronizer
    typedef struct packed {
        logic din;
        logic sclk;
        logic lat_en;
        logic blank;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // High-to-low transition between two consecutive samples
    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [N-1:0] q
);
    // q[0] is the stage next to the input; q[N-1] is the far end
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {q[N-2:0], din};
    end
endmodule

// File: rtl/sld_latch.sv
module sld_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Follows d on every system clock while load is high
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/sld_driver.sv
module sld_driver
    import sld_pkg::*;
#(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sin,
    input  logic         sclk,
    input  logic         latch_en,
    input  logic         blank,
    output logic [N-1:0] pout,
    output logic         sout
);
    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [CTL_W-1:0] sync_q;
    logic             sclk_prev;
    logic             shift_fire;
    logic [N-1:0]     chain_q;
    logic [N-1:0]     lat_q;

    always_comb begin
        ctl_raw        = '0;
        ctl_raw.din    = sin;
        ctl_raw.sclk   = sclk;
        ctl_raw.lat_en = latch_en;
        ctl_raw.blank  = blank;
    end

    sld_sync #(.W(CTL_W), .DEPTH(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (sync_q)
    );

    assign ctl_s = ctl_t'(sync_q);

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= ctl_s.sclk;
    end

    assign shift_fire = fell(sclk_prev, ctl_s.sclk);

    sld_shift #(.N(N)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_fire),
        .din      (ctl_s.din),
        .q        (chain_q)
    );

    sld_latch #(.N(N)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (ctl_s.lat_en),
        .d    (chain_q),
        .q    (lat_q)
    );

    assign pout = ctl_s.blank ? '0 : lat_q;
    assign sout = chain_q[N-1];
endmodule

// File: rtl/sld_driver_chk.sv
module sld_driver_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         blank,
    input logic [N-1:0] pout,
    input logic         sout,
    input logic         fire,
    input logic         din_s,
    input logic         len_s,
    input logic [N-1:0] chain,
    input logic [N-1:0] lat
);
    a_r1_shift_moves: assert property (@(posedge clk) disable iff (rst)
        fire |=> (chain[N-1:1] == $past(chain[N-2:0])) && (chain[0] == $past(din_s)));

    a_r2_steady_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(chain));

    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        len_s |=> lat == $past(chain));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !len_s |=> $stable(lat));

    a_r5_blank_low: assert property (@(posedge clk) disable iff (rst)
        (blank && $past(blank) && $past(blank, 2)) |-> pout == '0);

    a_r7_sout_on_shift: assert property (@(posedge clk) disable iff (rst)
        !$stable(sout) |-> $past(fire));

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pout == '0) && (sout == 1'b0));
endmodule

bind sld_driver sld_driver_chk #(.N(N)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .blank (blank),
    .pout  (pout),
    .sout  (sout),
    .fire  (shift_fire),
    .din_s (ctl_s.din),
    .len_s (ctl_s.lat_en),
    .chain (chain_q),
    .lat   (lat_q)
);

// File: tb/sld_driver_test.sv
module sld_driver_test;
    localparam int N = 32;

    typedef struct packed {
        logic [31:0] word;
        logic        blk;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'hDEAD_BEEF, 1'b0},
        '{32'h0000_0001, 1'b0},
        '{32'h8000_0000, 1'b1},
        '{32'h5A5A_A5A5, 1'b0},
        '{32'hFFFF_FFFF, 1'b1},
        '{32'h1357_9BDF, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sin = 1'b0, sclk = 1'b0, latch_en = 1'b0, blank = 1'b0;
    logic [N-1:0] pout_a, pout_b;
    logic sout_a, sout_b;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lat_model;

    always #10 clk = ~clk;

    sld_driver #(.N(N)) uut (
        .clk(clk), .rst(rst), .sin(sin), .sclk(sclk), .latch_en(latch_en),
        .blank(blank), .pout(pout_a), .sout(sout_a)
    );

    sld_driver #(.N(N)) uut_nx (
        .clk(clk), .rst(rst), .sin(sout_a), .sclk(sclk), .latch_en(latch_en),
        .blank(blank), .pout(pout_b), .sout(sout_b)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sin = b;
        wait_cyc(3);
        sclk = 1'b1;
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic shift_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) shift_bit(w[i]);
    endtask

    initial begin
        wait_cyc(150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // R8: cleared after reset
        check("R8 reset pout", {32'b0, pout_a}, 64'h0);
        check("R8 reset sout", {63'b0, sout_a}, 64'h0);
        check("R8 reset next pout", {32'b0, pout_b}, 64'h0);

        // R9 / R1: a single 1 enters at bit 0 and moves up one place per fall
        latch_en = 1'b1;
        wait_cyc(4);
        shift_bit(1'b1);
        wait_cyc(2);
        check("R9 first stage is bit0", {32'b0, pout_a}, 64'h1);
        shift_bit(1'b0);
        wait_cyc(2);
        check("R1 one place per fall", {32'b0, pout_a}, 64'h2);
        shift_bit(1'b1);
        wait_cyc(2);
        check("R1 new bit into stage1", {32'b0, pout_a}, 64'h5);

        // R2: steady low, then steady high, while sin toggles
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            sin = ~sin;
        end
        wait_cyc(4);
        check("R2 steady low no shift", {32'b0, pout_a}, 64'h5);
        sclk = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            sin = ~sin;
        end
        wait_cyc(4);
        check("R2 steady high no shift", {32'b0, pout_a}, 64'h5);
        sin = 1'b0;
        wait_cyc(3);
        sclk = 1'b0;
        wait_cyc(6);
        check("R1 shift on falling edge", {32'b0, pout_a}, 64'hA);
        latch_en = 1'b0;
        lat_model = 32'hA;
        wait_cyc(4);

        // Vector walk
        foreach (VECS[k]) begin
            blank = VECS[k].blk;
            wait_cyc(6);
            shift_word(VECS[k].word);
            wait_cyc(2);
            check(VECS[k].blk ? "R5 blank during load" : "R4 latch holds",
                  {32'b0, pout_a}, {32'b0, (VECS[k].blk ? 32'b0 : lat_model)});
            check("R7 sout is last stage", {63'b0, sout_a}, {63'b0, VECS[k].word[31]});
            latch_en = 1'b1;
            wait_cyc(6);
            check(VECS[k].blk ? "R5 blank hides latch" : "R3 latch follows",
                  {32'b0, pout_a}, {32'b0, (VECS[k].blk ? 32'b0 : VECS[k].word)});
            latch_en = 1'b0;
            lat_model = VECS[k].word;
            wait_cyc(4);
            if (VECS[k].blk) begin
                blank = 1'b0;
                wait_cyc(6);
                check("R6 unblank shows latch", {32'b0, pout_a}, {32'b0, lat_model});
            end
        end

        // R4: partial shift with latch closed
        shift_bit(1'b1);
        shift_bit(1'b0);
        shift_bit(1'b1);
        wait_cyc(2);
        check("R4 hold on partial shift", {32'b0, pout_a}, {32'b0, lat_model});

        // R7: 64-bit transfer through two devices
        begin
            logic [63:0] v;
            v = 64'hC3A5_0F1E_9B72_6D48;
            shift_word(v[63:32]);
            shift_word(v[31:0]);
            latch_en = 1'b1;
            wait_cyc(6);
            check("R7 chain low half", {32'b0, pout_a}, {32'b0, v[31:0]});
            check("R7 chain high half", {32'b0, pout_b}, {32'b0, v[63:32]});
            check("R7 chain far sout", {63'b0, sout_b}, {63'b0, v[63]});
            latch_en = 1'b0;
            wait_cyc(2);
        end

        // R8: reset in mid-operation
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(2);
        check("R8 mid reset pout", {pout_b, pout_a}, 64'h0);
        check("R8 mid reset sout", {62'b0, sout_b, sout_a}, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule